// File: doc/BRIEF.md
# Five-State Snooping Cache Coherence Controller

This block keeps the coherence state of every line of a small private cache that sits on a shared snooping bus. It accepts reads, writes and evictions from its own processor and snooped read and read-for-ownership requests seen on the bus. From each request and the line's present state it works out the next state. It also drives a bus read or ownership request, supplies data when it is the designated responder, and flags write-backs. Line states are Invalid (I), Shared (S), Exclusive (E), Modified (M) and Forward (F). Forward is a Shared copy whose holder is the single responder to snooped reads.

The line table is indexed directly by line number. A processor request and the bus snoop both address it in the same cycle. The table has one write port, so a snoop always wins and the processor request in that cycle is refused through `cpu_ready` and must be retried. All actions appear on registered outputs one cycle after the request edge. A read port (`look_line`/`look_state`) shows any line's state, with I=0, S=1, E=2, M=3, F=4. The `fwd_en` input picks between five-state operation and plain four-state operation, in which F is never entered.

Named transitions: fill-exclusive (I→E), fill-shared (I→S or I→F), read-hit (no change), silent upgrade (E→M), ownership (I/S/F→M with a bus request), snoop-invalidate (any→I), snoop-demote (M→S, E→S/F, F→S) and eviction (any→I).

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line reads state I (code 0) and `cpu_ack`, `bus_req_valid`, `wb_valid` and `supply_valid` are low.
- R2: A processor read (op 00) of an I line raises `bus_req_valid` with `bus_req_rfo`=0. The line fills in E when `fill_shared` is 0. When `fill_shared` is 1 it fills in F if `fwd_en`=1 and in S if `fwd_en`=0.
- R3: A processor read of a line in S, E, M or F is acknowledged without any bus request, and the state is unchanged.
- R4: A processor write (op 01) to an E line moves it to M without a bus request, and a write to an M line stays silently in M.
- R5: A processor write to a line in I, S or F raises `bus_req_valid` with `bus_req_rfo`=1, and the line ends in M.
- R6: A snooped read-for-ownership (`snp_rfo`=1) moves any line to I, and raises `wb_valid` only when the line was M.
- R7: A snooped read (`snp_rfo`=0) of an M line raises both `wb_valid` and `supply_valid`, and the line becomes S.
- R8: A snooped read of an E line raises `supply_valid` without a write-back. The line becomes F when `fwd_en`=1 and S when `fwd_en`=0.
- R9: A snooped read of an F line raises `supply_valid` and demotes it to S. A snooped read of an S or I line produces no output and leaves the state unchanged.
- R10: When `snp_req` and `cpu_req` are high in the same cycle, `cpu_ready` is low and only the snoop is served. The next cycle has no `cpu_ack`, and the processor's line is left unchanged.
- R11: An eviction (op 10) moves the line to I and raises `wb_valid` only when it was M. Evicting an E, S or F line is silent.
- R12: Every action is reported one cycle after its request edge. `bus_req_line`, `wb_line` and `supply_line` carry the line that was acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1 = five-state operation with F, 0 = four-state operation |
| cpu_req | input | 1 | Processor request valid |
| cpu_op | input | 2 | 00 read, 01 write, 10 evict, 11 no operation |
| cpu_line | input | LW | Line addressed by the processor |
| fill_shared | input | 1 | Bus shared signal sampled on a read fill |
| cpu_ready | output | 1 | Low when a snoop takes the table this cycle |
| cpu_ack | output | 1 | Processor request completed (one cycle later) |
| snp_req | input | 1 | Snooped bus request valid |
| snp_rfo | input | 1 | 1 = read-for-ownership, 0 = read |
| snp_line | input | LW | Line addressed by the snoop |
| bus_req_valid | output | 1 | Bus request issued for a processor access |
| bus_req_rfo | output | 1 | 1 = ownership request, 0 = read request |
| bus_req_line | output | LW | Line of the bus request |
| wb_valid | output | 1 | Modified data must be written back |
| wb_line | output | LW | Line being written back |
| supply_valid | output | 1 | This cache answers the snooped read |
| supply_line | output | LW | Line being supplied |
| look_line | input | LW | Line whose state is shown |
| look_state | output | 3 | State of `look_line`: I=0, S=1, E=2, M=3, F=4 |

## Verification
A snoop and a processor request can arrive in the same cycle, either to different lines or to the same line. The bench drives both on one edge. It expects `cpu_ready` low before the edge, the snoop's own write-back or supply outputs on the next cycle, and no `cpu_ack`. It then reads the processor's line through `look_state` to confirm that the refused request did not change it. A collision on the same line checks that only the snoop transition was applied.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        ST_INV = 3'd0,
        ST_SHR = 3'd1,
        ST_EXC = 3'd2,
        ST_MOD = 3'd3,
        ST_FWD = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } cpu_op_e;

    typedef struct packed {
        logic ack;
        logic bus_rd;
        logic bus_rfo;
        logic wb;
        logic supply;
    } act_t;

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [LW-1:0]   wline,
    input  line_st_e        wstate,
    input  logic [LW-1:0]   acc_line,
    output line_st_e        acc_state,
    input  logic [LW-1:0]   look_line,
    output line_st_e        look_state,
    output line_st_e        st_o [LINES]
);

    line_st_e st_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= ST_INV;
            end else if (we && (wline == LW'(g))) begin
                st_q[g] <= wstate;
            end
        end
        assign st_o[g] = st_q[g];
    end

    assign acc_state  = st_q[acc_line];
    assign look_state = st_q[look_line];

endmodule

// File: rtl/coh_next_state.sv
module coh_next_state
    import coh_pkg::*;
(
    input  logic      is_snoop,
    input  logic      snp_rfo,
    input  cpu_op_e   op,
    input  line_st_e  cur,
    input  logic      shared,
    input  logic      fwd_en,
    output line_st_e  nxt,
    output act_t      act
);

    // State transition
    always_comb begin
        nxt = cur;
        if (is_snoop) begin
            if (snp_rfo) begin
                nxt = ST_INV;
            end else begin
                unique case (cur)
                    ST_MOD:  nxt = ST_SHR;
                    ST_EXC:  nxt = fwd_en ? ST_FWD : ST_SHR;
                    ST_FWD:  nxt = ST_SHR;
                    ST_SHR:  nxt = ST_SHR;
                    ST_INV:  nxt = ST_INV;
                    default: nxt = cur;
                endcase
            end
        end else begin
            unique case (op)
                OP_RD: begin
                    if (cur == ST_INV) begin
                        if (!shared)     nxt = ST_EXC;
                        else if (fwd_en) nxt = ST_FWD;
                        else             nxt = ST_SHR;
                    end
                end
                OP_WR:    nxt = ST_MOD;
                OP_EVICT: nxt = ST_INV;
                OP_NONE:  nxt = cur;
                default:  nxt = cur;
            endcase
        end
    end

    // Actions
    always_comb begin
        act = '0;
        if (is_snoop) begin
            act.wb = (cur == ST_MOD);
            if (!snp_rfo) begin
                act.supply = (cur inside {ST_MOD, ST_EXC, ST_FWD});
            end
        end else begin
            unique case (op)
                OP_RD: begin
                    act.ack    = 1'b1;
                    act.bus_rd = (cur == ST_INV);
                end
                OP_WR: begin
                    act.ack     = 1'b1;
                    act.bus_rfo = (cur inside {ST_INV, ST_SHR, ST_FWD});
                end
                OP_EVICT: begin
                    act.ack = 1'b1;
                    act.wb  = (cur == ST_MOD);
                end
                OP_NONE: act = '0;
                default: act = '0;
            endcase
        end
    end

endmodule

// File: rtl/coh_out_reg.sv
module coh_out_reg
    import coh_pkg::*;
#(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_t          act_i,
    input  logic [LW-1:0] line_i,
    output act_t          act_q,
    output logic [LW-1:0] line_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            line_q <= '0;
        end else begin
            act_q  <= act_i;
            line_q <= line_i;
        end
    end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd_en,
    input  logic          cpu_req,
    input  logic [1:0]    cpu_op,
    input  logic [LW-1:0] cpu_line,
    input  logic          fill_shared,
    output logic          cpu_ready,
    output logic          cpu_ack,
    input  logic          snp_req,
    input  logic          snp_rfo,
    input  logic [LW-1:0] snp_line,
    output logic          bus_req_valid,
    output logic          bus_req_rfo,
    output logic [LW-1:0] bus_req_line,
    output logic          wb_valid,
    output logic [LW-1:0] wb_line,
    output logic          supply_valid,
    output logic [LW-1:0] supply_line,
    input  logic [LW-1:0] look_line,
    output logic [2:0]    look_state
);

    line_st_e      line_st [LINES];
    line_st_e      cur_st;
    line_st_e      nxt_st;
    line_st_e      look_st;
    act_t          act_raw;
    act_t          act_gated;
    act_t          act_q;
    logic [LW-1:0] acc_line;
    logic [LW-1:0] line_q;
    logic          cpu_take;
    logic          tbl_we;
    cpu_op_e       op_e;

    assign op_e      = cpu_op_e'(cpu_op);
    assign cpu_take  = cpu_req && !snp_req && (op_e != OP_NONE);
    assign tbl_we    = snp_req || cpu_take;
    assign acc_line  = snp_req ? snp_line : cpu_line;
    assign cpu_ready = !snp_req;
    assign act_gated = tbl_we ? act_raw : '0;

    coh_line_table #(.LINES(LINES)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (tbl_we),
        .wline      (acc_line),
        .wstate     (nxt_st),
        .acc_line   (acc_line),
        .acc_state  (cur_st),
        .look_line  (look_line),
        .look_state (look_st),
        .st_o       (line_st)
    );

    coh_next_state u_next (
        .is_snoop (snp_req),
        .snp_rfo  (snp_rfo),
        .op       (op_e),
        .cur      (cur_st),
        .shared   (fill_shared),
        .fwd_en   (fwd_en),
        .nxt      (nxt_st),
        .act      (act_raw)
    );

    coh_out_reg #(.LW(LW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act_gated),
        .line_i (acc_line),
        .act_q  (act_q),
        .line_q (line_q)
    );

    assign cpu_ack       = act_q.ack;
    assign bus_req_valid = act_q.bus_rd || act_q.bus_rfo;
    assign bus_req_rfo   = act_q.bus_rfo;
    assign bus_req_line  = line_q;
    assign wb_valid      = act_q.wb;
    assign wb_line       = line_q;
    assign supply_valid  = act_q.supply;
    assign supply_line   = line_q;
    assign look_state    = look_st;

endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic [1:0]    cpu_op,
    input logic [LW-1:0] cpu_line,
    input logic          snp_req,
    input logic          snp_rfo,
    input logic [LW-1:0] snp_line,
    input logic          cpu_ack,
    input logic          bus_req_valid,
    input logic          bus_req_rfo,
    input logic [LW-1:0] bus_req_line,
    input logic          supply_valid,
    input line_st_e      st [LINES]
);

    assert_collide_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && cpu_req) |=> !cpu_ack);

    assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !snp_req && cpu_op == 2'd1 && st[cpu_line] == ST_EXC)
        |=> (!bus_req_valid && st[$past(cpu_line)] == ST_MOD));

    assert_rfo_ends_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_rfo) |-> st[bus_req_line] == ST_MOD);

    assert_snoop_inval_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && snp_rfo) |=> st[$past(snp_line)] == ST_INV);

    assert_read_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_rfo)
        |-> (st[bus_req_line] inside {ST_EXC, ST_SHR, ST_FWD}));

    assert_supply_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_valid && bus_req_valid));

endmodule

bind coh_snoop_ctrl coh_snoop_chk #(.LINES(LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_op        (cpu_op),
    .cpu_line      (cpu_line),
    .snp_req       (snp_req),
    .snp_rfo       (snp_rfo),
    .snp_line      (snp_line),
    .cpu_ack       (cpu_ack),
    .bus_req_valid (bus_req_valid),
    .bus_req_rfo   (bus_req_rfo),
    .bus_req_line  (bus_req_line),
    .supply_valid  (supply_valid),
    .st            (line_st)
);

// File: tb/tb_coh_snoop_ctrl.sv
module tb_coh_snoop_ctrl;

    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);
    localparam logic [2:0] SI = 3'd0, SS = 3'd1, SE = 3'd2, SM = 3'd3, SF = 3'd4;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwd_en = 1'b1;
    logic          cpu_req = 1'b0;
    logic [1:0]    cpu_op = 2'd3;
    logic [LW-1:0] cpu_line = '0;
    logic          fill_shared = 1'b0;
    logic          cpu_ready, cpu_ack;
    logic          snp_req = 1'b0, snp_rfo = 1'b0;
    logic [LW-1:0] snp_line = '0;
    logic          bus_req_valid, bus_req_rfo, wb_valid, supply_valid;
    logic [LW-1:0] bus_req_line, wb_line, supply_line;
    logic [LW-1:0] look_line = '0;
    logic [2:0]    look_state;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit ack; bit bv; bit rfo; bit wb; bit sup;
        int ln; logic [2:0] st; string tag;
    } exp_t;
    exp_t q[$];
    logic [2:0] mst [LINES];

    always #4 clk = ~clk;

    coh_snoop_ctrl #(.LINES(LINES)) dut (.*);

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    // Monitor: compares registered outputs one cycle after each request
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                bit ok;
                e  = q.pop_front();
                ok = (cpu_ack == e.ack) && (bus_req_valid == e.bv) &&
                     (bus_req_rfo == (e.bv && e.rfo)) && (wb_valid == e.wb) &&
                     (supply_valid == e.sup) && (look_state == e.st);
                if (e.bv)  ok = ok && (bus_req_line == LW'(e.ln));
                if (e.wb)  ok = ok && (wb_line == LW'(e.ln));
                if (e.sup) ok = ok && (supply_line == LW'(e.ln));
                check(ok, e.tag, $sformatf(
                    "act ack=%0d bus=%0d rfo=%0d wb=%0d sup=%0d st=%0d line=%0d exp ack=%0d bus=%0d rfo=%0d wb=%0d sup=%0d st=%0d line=%0d",
                    cpu_ack, bus_req_valid, bus_req_rfo, wb_valid, supply_valid, look_state,
                    bus_req_line, e.ack, e.bv, e.rfo, e.wb, e.sup, e.st, e.ln));
            end
        end
    end

    // Driver: computes expectations from the requirements and drives one request
    task automatic drive(input bit c, input logic [1:0] op, input int cl, input bit sh,
                         input bit s, input bit rfo, input int sl, input string tag);
        exp_t e;
        logic [2:0] cur;
        e.ack = 0; e.bv = 0; e.rfo = 0; e.wb = 0; e.sup = 0; e.tag = tag;
        if (s) begin
            cur  = mst[sl];
            e.ln = sl;
            e.wb = (cur == SM);
            if (rfo) mst[sl] = SI;
            else begin
                e.sup = (cur == SM) || (cur == SE) || (cur == SF);
                if (cur == SM || cur == SF) mst[sl] = SS;
                else if (cur == SE) mst[sl] = fwd_en ? SF : SS;
            end
            e.st = mst[sl];
        end else begin
            cur   = mst[cl];
            e.ln  = cl;
            e.ack = 1;
            if (op == RD) begin
                if (cur == SI) begin
                    e.bv = 1;
                    mst[cl] = !sh ? SE : (fwd_en ? SF : SS);
                end
            end else if (op == WR) begin
                if (cur == SI || cur == SS || cur == SF) begin e.bv = 1; e.rfo = 1; end
                mst[cl] = SM;
            end else begin
                e.wb = (cur == SM);
                mst[cl] = SI;
            end
            e.st = mst[cl];
        end
        @(negedge clk);
        cpu_req = c; cpu_op = op; cpu_line = LW'(cl); fill_shared = sh;
        snp_req = s; snp_rfo = rfo; snp_line = LW'(sl);
        #1;
        if (c) check(cpu_ready == !s, "R10",
            $sformatf("cpu_ready act=%0d exp=%0d", cpu_ready, !s));
        @(posedge clk);
        #1;
        cpu_req = 0; cpu_op = 2'd3; snp_req = 0; snp_rfo = 0; fill_shared = 0;
        look_line = LW'(e.ln);
        q.push_back(e);
    endtask

    task automatic cpu(input logic [1:0] op, input int ln, input bit sh, input string tag);
        drive(1, op, ln, sh, 0, 0, 0, tag);
    endtask

    task automatic snp(input bit rfo, input int ln, input string tag);
        drive(0, RD, 0, 0, 1, rfo, ln, tag);
    endtask

    task automatic peek(input int ln, input logic [2:0] exp_st, input string tag);
        @(negedge clk);
        #2;
        look_line = LW'(ln);
        #1;
        check(look_state == exp_st, tag,
            $sformatf("line %0d state act=%0d exp=%0d", ln, look_state, exp_st));
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) mst[i] = SI;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check(!cpu_ack && !bus_req_valid && !wb_valid && !supply_valid, "R1",
            $sformatf("outputs act=%0d%0d%0d%0d exp=0000", cpu_ack, bus_req_valid, wb_valid, supply_valid));
        for (int i = 0; i < LINES; i++) peek(i, SI, "R1");

        cpu(RD, 0, 0, "R2");   // I -> E, bus read
        cpu(RD, 0, 0, "R3");   // hit in E
        cpu(WR, 0, 0, "R4");   // E -> M silent
        cpu(WR, 0, 0, "R4");   // M stays M silent
        cpu(RD, 0, 0, "R3");   // hit in M
        snp(0, 0, "R7");       // M -> S with write-back and supply
        cpu(RD, 0, 0, "R3");   // hit in S
        cpu(RD, 1, 1, "R2");   // shared fill -> F
        snp(0, 1, "R9");       // F -> S, supply
        snp(0, 1, "R9");       // S: no response
        cpu(WR, 1, 0, "R5");   // S -> M via ownership request
        snp(1, 1, "R6");       // M -> I with write-back
        cpu(WR, 2, 0, "R5");   // I -> M via ownership request
        cpu(RD, 3, 0, "R2");   // E
        snp(0, 3, "R8");       // E -> F, supply
        cpu(WR, 3, 0, "R5");   // F -> M via ownership request
        cpu(EV, 3, 0, "R11");  // M eviction writes back
        cpu(EV, 0, 0, "R11");  // S eviction silent
        cpu(EV, 4, 0, "R11");  // I eviction: nothing
        cpu(RD, 5, 0, "R2");
        cpu(EV, 5, 0, "R11");  // E eviction silent
        cpu(RD, 5, 1, "R2");   // F
        snp(1, 5, "R6");       // F -> I silent
        snp(0, 6, "R9");       // I: no response
        snp(1, 6, "R6");       // I stays I

        // R10 collisions: different lines, then the same line
        drive(1, WR, 7, 0, 1, 1, 2, "R10");
        peek(7, SI, "R10");
        cpu(RD, 6, 0, "R2");   // line 6 -> E
        drive(1, WR, 6, 0, 1, 0, 6, "R10");
        peek(6, SF, "R10");

        // Four-state operation
        fwd_en = 1'b0;
        cpu(RD, 4, 1, "R2");   // shared fill -> S
        snp(0, 4, "R9");       // S: no response
        cpu(RD, 7, 0, "R2");
        snp(0, 7, "R8");       // E -> S, supply
        cpu(WR, 7, 0, "R5");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule